// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block is an eight-tap FIR filter that forms its products without multipliers, using distributed arithmetic. Each new sample pushes an eight-deep delay line forward by one position. The block then copies every tap into its own serial shift register. Over sixteen bit cycles, the low bit of each serial register is read out. Four of these bits address one table and the other four address a second table. Each table holds every possible sum of four coefficients. The two table outputs are added, and that sum is folded into an accumulator that shifts one place right per cycle. The sign-bit cycle subtracts its sum instead of adding it, because samples are two's complement.

Samples enter on a valid/ready stream. The block accepts one only when `in_ready` is high, and `in_ready` is low for as long as the block is computing or holding a result. The result leaves on a second valid/ready stream. After `out_valid` rises, `out_result` stays constant until the cycle where `out_ready` is also high. Back-pressure at the output therefore stalls sample intake. The coefficients are parameters and are fixed at elaboration.

Top module: `fir_da_serial`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0 and `in_ready` is 1, and every tap of the delay line holds zero.
- R2: `in_ready` is the inverse of `busy`. A sample is taken only on a rising edge where `in_valid` and `in_ready` are both 1.
- R3: `in_valid` has no effect while `in_ready` is 0. Such a sample never enters the delay line, so later results are the same as if it had never been offered.
- R4: `out_valid` rises on the 16th rising edge after the edge that accepted a sample. `busy` is 1 from the accepting edge until the result is taken.
- R5: `out_result` is the exact 35-bit two's complement value of sum over k=0..7 of COEFS[k]·x[n−k]. Here x[n] is the newest accepted sample, COEFS[k] is bits [16k+15:16k] of the coefficient parameter, and samples from before reset count as zero.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_result` does not change.
- R7: Full-scale inputs give exact results. This covers all taps at −32768 or all at 32767, where the negative sign-bit weight −2^15 dominates.
- R8: On the edge where `out_valid` and `out_ready` are both 1, the result is taken. `out_valid` falls and `in_ready` returns to 1 on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 16 | Two's complement sample |
| busy | output | 1 | Computing or holding a result |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 35 | Two's complement filter output |

## Verification
A corrupted serial register or table entry produces a wrong sum on the very next result, 16 cycles after the sample that exposes it. A delay-line fault reaches the ports more slowly: it can stay hidden for up to eight results, until the damaged tap meets a nonzero coefficient. For this reason the stimulus includes impulses, which walk a single value through every tap in turn. A bit counter that is off by one shows at the ports either as wrong `out_valid` timing or as a sign error. The sign error appears at once on any sample whose top bit is set.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } da_state_e;

  localparam int unsigned TAB_IN = 4;
endpackage

// File: rtl/fir_da_table.sv
module fir_da_table #(
  parameter int unsigned W  = 16,
  parameter int unsigned OW = 18,
  parameter logic [fir_da_pkg::TAB_IN*W-1:0] COEFS = '0
) (
  input  logic [fir_da_pkg::TAB_IN-1:0] addr,
  output logic signed [OW-1:0]          sum_out
);
  localparam int unsigned NIN  = fir_da_pkg::TAB_IN;
  localparam int unsigned NENT = 1 << NIN;

  function automatic logic signed [OW-1:0] subset_sum(input int unsigned sel);
    logic signed [OW-1:0] acc;
    logic [W-1:0]         c;
    acc = '0;
    for (int k = 0; k < NIN; k++) begin
      c = COEFS[k*W +: W];
      if (sel[k]) acc = acc + {{(OW-W){c[W-1]}}, c};
    end
    return acc;
  endfunction

  logic signed [OW-1:0] rom [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign rom[e] = subset_sum(e);
  end

  assign sum_out = rom[addr];
endmodule

// File: rtl/fir_da_delay.sv
module fir_da_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned NTAPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic [W-1:0]     sample,
  output logic [NTAPS-1:0] bits
);
  logic [W-1:0] line [NTAPS];
  logic [W-1:0] sreg [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin
        line[k] <= '0;
        sreg[k] <= '0;
      end
    end else if (load) begin
      line[0] <= sample;
      sreg[0] <= sample;
      for (int k = 1; k < NTAPS; k++) begin
        line[k] <= line[k-1];
        sreg[k] <= line[k-1];
      end
    end else if (shift_en) begin
      for (int k = 0; k < NTAPS; k++) sreg[k] <= sreg[k] >> 1;
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_bit
    assign bits[k] = sreg[k][0];
  end

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(line[0]) && $stable(line[NTAPS-1])));
  // R2
  line_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (line[0] == $past(sample)));
endmodule

// File: rtl/fir_da_accum.sv
module fir_da_accum #(
  parameter int unsigned W    = 16,
  parameter int unsigned SUMW = 19,
  parameter int unsigned OUTW = 35
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   en,
  input  logic signed [SUMW-1:0] w_in,
  output logic                   last,
  output logic [OUTW-1:0]        result
);
  localparam int unsigned HIW = OUTW - W;
  localparam int unsigned TW  = HIW + 2;
  localparam int unsigned CW  = $clog2(W);

  logic signed [HIW-1:0] hi;
  logic [W-1:0]          lo;
  logic [CW-1:0]         cnt;
  logic signed [TW-1:0]  hi_x, w_x, t;

  assign last = en && (cnt == CW'(W-1));
  assign hi_x = {{(TW-HIW){hi[HIW-1]}}, hi};
  assign w_x  = {{(TW-SUMW){w_in[SUMW-1]}}, w_in};
  assign t    = last ? (hi_x - w_x) : (hi_x + w_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi  <= '0;
      lo  <= '0;
      cnt <= '0;
    end else if (clear) begin
      hi  <= '0;
      lo  <= '0;
      cnt <= '0;
    end else if (en) begin
      hi  <= t[HIW:1];
      lo  <= {t[0], lo[W-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  assign result = {hi, lo};

  // R4
  cnt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  // R6
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !en) |=> $stable(result));
endmodule

// File: rtl/fir_da_serial.sv
module fir_da_serial #(
  parameter int unsigned W     = 16,
  parameter int unsigned NTAPS = 8,
  parameter int unsigned OUTW  = 35,
  parameter logic [NTAPS*W-1:0] COEFS = {
    16'hF448, 16'h03E8, 16'hFFFF, 16'h0007,
    16'h7FFF, 16'hB1E0, 16'h3039, 16'h8000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_sample,
  output logic            busy,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUTW-1:0] out_result
);
  import fir_da_pkg::*;

  localparam int unsigned NTAB = NTAPS / TAB_IN;
  localparam int unsigned TABW = W + $clog2(TAB_IN);
  localparam int unsigned SUMW = TABW + $clog2(NTAB);

  da_state_e state;
  logic accept, running, last;
  logic [NTAPS-1:0] bits;
  logic signed [TABW-1:0] tab_out [NTAB];
  logic signed [SUMW-1:0] wsum;

  assign running   = (state == ST_RUN);
  assign out_valid = (state == ST_HOLD);
  assign busy      = (state != ST_IDLE);
  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_RUN;
        ST_RUN:  if (last) state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  fir_da_delay #(.W(W), .NTAPS(NTAPS)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift_en(running),
    .sample(in_sample), .bits(bits));

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    fir_da_table #(.W(W), .OW(TABW),
                   .COEFS(COEFS[t*TAB_IN*W +: TAB_IN*W])) u_tab (
      .addr(bits[t*TAB_IN +: TAB_IN]), .sum_out(tab_out[t]));
  end

  always_comb begin
    wsum = '0;
    for (int t = 0; t < NTAB; t++)
      wsum = wsum + {{(SUMW-TABW){tab_out[t][TABW-1]}}, tab_out[t]};
  end

  fir_da_accum #(.W(W), .SUMW(SUMW), .OUTW(OUTW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(running),
    .w_in(wsum), .last(last), .result(out_result));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !out_valid));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
  // R4
  run_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> out_valid);
endmodule

// File: tb/tb_fir_da_serial.sv
module tb_fir_da_serial;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [15:0] in_sample = '0;
  logic in_ready, busy, out_valid;
  logic signed [34:0] out_result;

  int checks = 0, fails = 0;
  longint coef [8] = '{-32768, 12345, -20000, 32767, 7, -1, 1000, -3000};
  longint hist [8] = '{default: 0};

  always #5 clk = ~clk;

  fir_da_serial dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_out();
    longint s = 0;
    for (int k = 0; k < 8; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  task automatic push(input logic [15:0] x, input bit junk, input int wait_cyc);
    int cnt;
    logic signed [34:0] held;
    @(negedge clk);
    check("R2 in_ready before offer", in_ready, 1);
    in_valid = 1; in_sample = x;
    @(posedge clk);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(x));
    @(negedge clk);
    in_valid = 0;
    check("R4 busy after accept", busy, 1);
    cnt = 0;
    if (junk) begin
      check("R2 in_ready low while busy", in_ready, 0);
      in_valid = 1; in_sample = 16'h5A5A;
      repeat (3) begin @(negedge clk); cnt++; end
      in_valid = 0;
    end
    while (!out_valid && cnt < 40) begin @(negedge clk); cnt++; end
    check("R4 latency", cnt, 16);
    check("R5/R3/R7 result", longint'(out_result), ref_out());
    held = out_result;
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      check("R6 hold valid", out_valid, 1);
      check("R6 hold result", longint'(out_result), longint'(held));
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R8 valid drop", out_valid, 0);
    check("R8 ready back", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 idle valid", out_valid, 0);
    push(16'h0000, 0, 0);                 // R1: zero line gives zero
    push(16'h0001, 0, 0);                 // impulse walks every tap
    for (int i = 0; i < 8; i++) push(16'h0000, i[0], i % 3);
    for (int i = 0; i < 8; i++) push(16'h8000, 0, 0);   // R7 negative full scale
    for (int i = 0; i < 8; i++) push(16'h7FFF, 1, 1);   // R7 positive full scale
    push(16'h8000, 0, 0);
    push(16'hFFFF, 1, 0);
    for (int i = 0; i < 120; i++)
      push(16'($urandom), ($urandom % 4) == 0, $urandom % 4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule